// File: doc/BRIEF.md
# Scaler Output Write-Address Sequencer

This block generates the memory write addresses for the frame that an image scaler produces. The scaler always writes its output to memory. Software programs four settings through a small register port: the output width and height, the byte address of the upper-left pixel, and the byte distance between the starts of consecutive rows. The block also takes the vertical scale setting, because the widest legal output depends on it.

The block checks the settings continuously and shows the result on a level error flag. A start pulse with legal settings makes the block walk the frame one row at a time. It issues one 32-byte-aligned address for each 32-byte burst of output data, on a valid/ready stream. When the last address has been taken it pulses done. A start pulse with illegal settings issues nothing and gives an immediate done. Output pixels are interleaved 4:2:2 at two bytes each.

Top module: `scaler_outaddr_gen`

## Requirements
- R1: The low 5 bits written to the start-address and row-offset registers are dropped and read as zero, so every issued address is a multiple of 32.
- R2: A width below 16 pixels makes `cfgErr` high.
- R3: An odd width makes `cfgErr` high, so that Cb and Cr sample counts match.
- R4: The width limit is 4096 when the vertical scale field plus one is 512 or less. It is 1650 when that sum is above 512. A larger width makes `cfgErr` high. With a 12-bit width field, every even width from 16 up is legal in the first case.
- R5: A height of zero makes `cfgErr` high. Any other legal setting keeps `cfgErr` low.
- R6: After a legal start, the addresses come out in ascending row order, and in ascending burst order within each row. Burst k of row r has address start + r·offset + 32·k (modulo 2^32). Each row has ceil(width·2/32) bursts.
- R7: While `burstValid` is high and `burstReady` is low, `burstValid` stays high and `burstAddr` does not change.
- R8: `done` is high for exactly the one cycle that follows acceptance of the final burst. `burstValid` is low in that cycle and afterwards.
- R9: A start while `cfgErr` is high issues no address, and `done` is high in the cycle after the start.
- R10: A start that arrives while a frame is being issued is ignored: the running sequence does not change and no second frame follows.
- R11: Register writes take effect on the clock edge where `cfgWe` is high. The register is chosen by `cfgSel`: 0 = size (width in bits 11:0, height in bits 27:16), 1 = start address, 2 = row offset, 3 = vertical scale field (bits 9:0). A frame uses the values held just before its start edge. Writes made during the frame, or on the start cycle itself, do not affect it.
- R12: After reset, `burstValid` and `done` are low, and `cfgErr` is high because width and height reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Register write enable |
| cfgSel | input | 2 | Register select |
| cfgWdata | input | 32 | Register write data |
| cfgErr | output | 1 | Current settings are illegal |
| start | input | 1 | Begin a frame |
| done | output | 1 | One-cycle end-of-frame pulse |
| burstAddr | output | 32 | Burst byte address |
| burstValid | output | 1 | Address is valid |
| burstReady | input | 1 | Consumer takes the address |

## Verification
Two things can happen in the same cycle: a register write and a start pulse. Likewise, a stray start can arrive while a frame is running. The bench writes a new width on the very edge of a start, and writes a new row offset and pulses start again in the middle of a frame. The expected address list is still computed from the settings held before the start. Any address built from the new values, or a second frame after done, is reported. Random stall patterns on ready surround both events.

// File: rtl/scaler_outaddr_pkg.sv
package scaler_outaddr_pkg;
  typedef struct packed {
    logic load;
    logic nextBurst;
    logic nextRow;
  } addrStrobes_t;

  typedef enum logic {ST_IDLE, ST_RUN} seqState_t;
endpackage

// File: rtl/scaler_outaddr_cfg.sv
module scaler_outaddr_cfg #(
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int DIM_W         = 12,
  parameter int VFAC_W        = 10,
  parameter int ALIGN_BITS    = 5,
  parameter int MIN_WIDTH     = 16,
  parameter int MAX_WIDTH_UP  = 4096,
  parameter int MAX_WIDTH_DN  = 1650,
  parameter int VFAC_KNEE     = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgWdata,
  output logic [DIM_W-1:0]  width,
  output logic [DIM_W-1:0]  height,
  output logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] rowOffset,
  output logic              cfgErr
);
  localparam int HGT_LSB = 16;
  localparam logic [DIM_W:0]  MIN_W_C  = (DIM_W+1)'(MIN_WIDTH);
  localparam logic [DIM_W:0]  MAX_UP_C = (DIM_W+1)'(MAX_WIDTH_UP);
  localparam logic [DIM_W:0]  MAX_DN_C = (DIM_W+1)'(MAX_WIDTH_DN);
  localparam logic [VFAC_W:0] KNEE_C   = (VFAC_W+1)'(VFAC_KNEE);

  logic [VFAC_W-1:0] vScale;
  logic [ADDR_W-ALIGN_BITS-1:0] startHi, offsetHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      width    <= '0;
      height   <= '0;
      startHi  <= '0;
      offsetHi <= '0;
      vScale   <= '0;
    end else if (cfgWe) begin
      case (cfgSel)
        2'd0: begin
          width  <= cfgWdata[DIM_W-1:0];
          height <= cfgWdata[HGT_LSB+DIM_W-1:HGT_LSB];
        end
        2'd1: startHi  <= cfgWdata[ADDR_W-1:ALIGN_BITS];
        2'd2: offsetHi <= cfgWdata[ADDR_W-1:ALIGN_BITS];
        default: vScale <= cfgWdata[VFAC_W-1:0];
      endcase
    end
  end

  // low address bits are hard zero
  assign startAddr = {startHi, {ALIGN_BITS{1'b0}}};
  assign rowOffset = {offsetHi, {ALIGN_BITS{1'b0}}};

  logic [VFAC_W:0] vFactor;
  logic            downMode;
  logic [DIM_W:0]  widthExt;
  logic            widthOk;

  always_comb begin
    vFactor  = {1'b0, vScale} + 1'b1;
    downMode = vFactor > KNEE_C;
    widthExt = {1'b0, width};
    widthOk  = (widthExt >= MIN_W_C) && !width[0] &&
               (downMode ? (widthExt <= MAX_DN_C) : (widthExt <= MAX_UP_C));
    cfgErr   = !widthOk || (height == '0);
  end
endmodule

// File: rtl/scaler_outaddr_dp.sv
module scaler_outaddr_dp
  import scaler_outaddr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DIM_W       = 12,
  parameter int BURST_BYTES = 32,
  parameter int PIX_BYTES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  addrStrobes_t      strobes,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] rowOffset,
  output logic [ADDR_W-1:0] burstAddr,
  output logic              lastBurst,
  output logic              lastRow
);
  localparam int ALIGN_BITS = $clog2(BURST_BYTES);
  localparam int BYTE_W     = DIM_W + $clog2(PIX_BYTES) + 1;

  logic [BYTE_W-1:0] rowBytes, burstsAll;
  logic [BYTE_W-1:0] burstIdx, burstLastIdx;
  logic [DIM_W-1:0]  rowIdx, rowLastIdx;
  logic [ADDR_W-1:0] rowBase, curAddr, offsetQ, rowNext;

  always_comb begin
    rowBytes  = BYTE_W'(width) * BYTE_W'(PIX_BYTES);
    burstsAll = (rowBytes + BYTE_W'(BURST_BYTES - 1)) >> ALIGN_BITS;
    rowNext   = rowBase + offsetQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowBase      <= '0;
      curAddr      <= '0;
      offsetQ      <= '0;
      burstIdx     <= '0;
      burstLastIdx <= '0;
      rowIdx       <= '0;
      rowLastIdx   <= '0;
    end else if (strobes.load) begin
      rowBase      <= startAddr;
      curAddr      <= startAddr;
      offsetQ      <= rowOffset;
      burstIdx     <= '0;
      burstLastIdx <= burstsAll - 1'b1;
      rowIdx       <= '0;
      rowLastIdx   <= height - 1'b1;
    end else if (strobes.nextRow) begin
      rowBase  <= rowNext;
      curAddr  <= rowNext;
      burstIdx <= '0;
      rowIdx   <= rowIdx + 1'b1;
    end else if (strobes.nextBurst) begin
      curAddr  <= curAddr + ADDR_W'(BURST_BYTES);
      burstIdx <= burstIdx + 1'b1;
    end
  end

  assign burstAddr = curAddr;
  assign lastBurst = burstIdx == burstLastIdx;
  assign lastRow   = rowIdx == rowLastIdx;

  // R1
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstAddr[ALIGN_BITS-1:0] == '0);

  // R6
  row_step_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.nextRow |-> lastBurst && !lastRow);
endmodule

// File: rtl/scaler_outaddr_ctrl.sv
module scaler_outaddr_ctrl
  import scaler_outaddr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         cfgErr,
  input  logic         burstReady,
  input  logic         lastBurst,
  input  logic         lastRow,
  output addrStrobes_t strobes,
  output logic         burstValid,
  output logic         done
);
  seqState_t state;
  logic      accept, frameEnd;

  always_comb begin
    accept     = (state == ST_RUN) && burstReady;
    frameEnd   = accept && lastBurst && lastRow;
    strobes    = '0;
    strobes.load      = (state == ST_IDLE) && start && !cfgErr;
    strobes.nextRow   = accept && lastBurst && !lastRow;
    strobes.nextBurst = accept && !lastBurst;
    burstValid = state == ST_RUN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (cfgErr) done  <= 1'b1;
          else        state <= ST_RUN;
        end
        default: if (frameEnd) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  // R9
  err_start_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && start && cfgErr |=> done && !burstValid);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !burstValid);
endmodule

// File: rtl/scaler_outaddr_gen.sv
module scaler_outaddr_gen
  import scaler_outaddr_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int DIM_W       = 12,
  parameter int VFAC_W      = 10,
  parameter int BURST_BYTES = 32,
  parameter int PIX_BYTES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgWdata,
  output logic              cfgErr,
  input  logic              start,
  output logic              done,
  output logic [ADDR_W-1:0] burstAddr,
  output logic              burstValid,
  input  logic              burstReady
);
  localparam int ALIGN_BITS = $clog2(BURST_BYTES);

  logic [DIM_W-1:0]  width, height;
  logic [ADDR_W-1:0] startAddr, rowOffset;
  logic              lastBurst, lastRow;
  addrStrobes_t      strobes;

  scaler_outaddr_cfg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIM_W(DIM_W), .VFAC_W(VFAC_W),
    .ALIGN_BITS(ALIGN_BITS)
  ) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .width(width), .height(height), .startAddr(startAddr),
    .rowOffset(rowOffset), .cfgErr(cfgErr)
  );

  scaler_outaddr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgErr(cfgErr),
    .burstReady(burstReady), .lastBurst(lastBurst), .lastRow(lastRow),
    .strobes(strobes), .burstValid(burstValid), .done(done)
  );

  scaler_outaddr_dp #(
    .ADDR_W(ADDR_W), .DIM_W(DIM_W), .BURST_BYTES(BURST_BYTES),
    .PIX_BYTES(PIX_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .width(width), .height(height),
    .startAddr(startAddr), .rowOffset(rowOffset), .burstAddr(burstAddr),
    .lastBurst(lastBurst), .lastRow(lastRow)
  );

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstValid && !burstReady |=> burstValid && $stable(burstAddr));
endmodule

// File: tb/scaler_outaddr_gen_bench.sv
module scaler_outaddr_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgWdata = '0;
  logic        start = 1'b0;
  logic        burstReady = 1'b0;
  logic        cfgErr, done, burstValid;
  logic [31:0] burstAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  scaler_outaddr_gen u_scaler_outaddr_gen (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgErr(cfgErr), .start(start), .done(done), .burstAddr(burstAddr),
    .burstValid(burstValid), .burstReady(burstReady)
  );

  function automatic logic [31:0] expAddr(logic [31:0] s, logic [31:0] o, int r, int k);
    return (s & ~32'h1F) + 32'(r) * (o & ~32'h1F) + 32'(k) * 32'd32;
  endfunction

  function automatic bit expErr(int w, int h, int vs);
    int lim = (vs + 1 <= 512) ? 4096 : 1650;
    return (w < 16) || (w % 2 != 0) || (w > lim) || (h == 0);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrCfg(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // disturb: width write on the start cycle, offset write and stray start mid-frame (R10, R11)
  task automatic runFrame(int w, int h, logic [31:0] s, logic [31:0] o, int vs, bit disturb);
    bit e = expErr(w, h, vs);
    int total = ((w + 15) / 16) * h;
    int bpr = (w + 15) / 16;
    int idx = 0;
    int cyc = 0;
    bit stalled = 0;
    bit bad = 0;
    logic [31:0] prevAddr = '0;
    wrCfg(2'd0, {4'h0, 12'(h), 4'h0, 12'(w)});
    wrCfg(2'd1, s);
    wrCfg(2'd2, o);
    wrCfg(2'd3, 32'(vs));
    @(negedge clk);
    // R2 R3 R4 R5
    check(cfgErr == e, "R2/R3/R4/R5 cfgErr", {31'b0, cfgErr}, {31'b0, e});
    start = 1'b1;
    if (disturb) begin cfgWe = 1'b1; cfgSel = 2'd0; cfgWdata = {4'h0, 12'(h), 4'h0, 12'd96}; end
    @(negedge clk);
    start = 1'b0; cfgWe = 1'b0;
    if (e) begin
      // R9
      check(done && !burstValid, "R9 done after rejected start", {30'b0, done, burstValid}, 32'h2);
      @(negedge clk);
      check(!done && !burstValid, "R9 no address after rejected start", {30'b0, done, burstValid}, 32'h0);
      return;
    end
    while (idx < total && cyc < 5000) begin
      if (stalled) begin
        // R7
        check(burstValid && burstAddr == prevAddr, "R7 stall hold", burstAddr, prevAddr);
      end
      if (done) bad = 1;
      cfgWe = 1'b0; start = 1'b0;
      if (disturb && idx == 2) begin cfgWe = 1'b1; cfgSel = 2'd2; cfgWdata = 32'h0007_7700; end
      if (disturb && idx == 1) start = 1'b1;
      burstReady = ($urandom % 4) != 0;
      if (burstValid && burstReady) begin
        // R6 R1
        check(burstAddr == expAddr(s, o, idx / bpr, idx % bpr), "R6 address",
              burstAddr, expAddr(s, o, idx / bpr, idx % bpr));
        idx++;
        stalled = 0;
      end else begin
        stalled = burstValid;
        prevAddr = burstAddr;
      end
      cyc++;
      @(negedge clk);
    end
    cfgWe = 1'b0; start = 1'b0; burstReady = 1'b0;
    check(!bad, "R8 no early done", {31'b0, bad}, 32'h0);
    // R8
    check(done && !burstValid, "R8 done pulse", {30'b0, done, burstValid}, 32'h2);
    @(negedge clk);
    check(!done && !burstValid, "R8/R10 quiet after done", {30'b0, done, burstValid}, 32'h0);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R12
    check(!burstValid && !done && cfgErr, "R12 reset state",
          {29'b0, burstValid, done, cfgErr}, 32'h1);
    rstN = 1'b1;
    @(negedge clk);
    check(!burstValid && !done && cfgErr, "R12 after reset release",
          {29'b0, burstValid, done, cfgErr}, 32'h1);

    runFrame(14, 2, 32'h1000, 32'h400, 0, 0);              // R2
    runFrame(15, 2, 32'h1000, 32'h400, 0, 0);              // R2
    runFrame(16, 3, 32'h1000, 32'h400, 0, 0);              // R2 lower edge legal
    runFrame(17, 2, 32'h1000, 32'h400, 0, 0);              // R3
    runFrame(40, 0, 32'h1000, 32'h400, 0, 0);              // R5
    runFrame(1650, 2, 32'h2000_0000, 32'h1000, 600, 0);    // R4 down limit legal
    runFrame(1652, 2, 32'h2000_0000, 32'h1000, 600, 0);    // R4 down limit exceeded
    runFrame(2000, 1, 32'h3000_0000, 32'h1000, 512, 0);    // R4 factor 513
    runFrame(4094, 1, 32'h3000_0000, 32'h2000, 511, 0);    // R4 factor 512
    runFrame(40, 3, 32'h1000_001F, 32'h0000_0105, 5, 0);   // R1 low bits dropped
    runFrame(64, 3, 32'hFFFF_FF00, 32'h0000_0100, 7, 0);   // R6 wraparound
    runFrame(48, 3, 32'h0004_0000, 32'h0000_0200, 9, 1);   // R10 R11
    for (int i = 0; i < 25; i++) begin
      int w = 16 + 2 * int'($urandom % 73);
      int h = 1 + int'($urandom % 5);
      int vs = int'($urandom % 1024);
      runFrame(w, h, $urandom, $urandom % 32'h10000, vs, (i % 6) == 5);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule